// File: doc/BRIEF.md
# Clock-Controlled Jumping Step Keystream Generator

This block produces a pseudo-random keystream from three linear feedback shift registers. A long control register steers the block: each round it advances once, and its least significant bit picks which of two shorter generating registers advances while the other holds. The chosen register does not advance just once. It jumps by a variable count formed from a few control-register bits, so the generating sequences are decimated irregularly.

The jump length is one plus a small binary number. The bits of that number are picked from the control register by configurable index fields. Each index drives a decoder whose one-hot output is ANDed with the control register and OR-reduced. A three-state one-hot sequencer steps the registers through a down-counter. Only one register advances in any cycle, under a per-register enable within a single clock domain. After every finished round, a one-cycle strobe marks the new keystream bit. A parameter selects whether the control register's output joins the output XOR.

A user seeds all three registers through a load pulse, holds the index fields steady, and collects one bit per strobe.

Top module: `ccjs_keygen`

## Requirements
- R1: After reset all three registers hold the value 1, the sequencer is in its control state and `valid_o` is low.
- R2: Each register advances by shifting toward bit 0, and the new top bit is the parity of (state AND tap mask). Its output bit is bit 0. The default masks are 0x1B for the 64-bit control register, 0x03 for the 7-bit register A and 0x05 for the 5-bit register B.
- R3: In the control state, the control register advances exactly once. The branch is decided by its bit 0 as it was before that advance.
- R4: When that bit is 1, register A advances `delta_a` times while register B holds. When it is 0, register B advances `delta_b` times while register A holds.
- R5: `delta` = 1 + sum over k of (control bit at index field k) × 2^k. Field k occupies bits [6k+5:6k] of the index port (`idx_a_i` for A, `idx_b_i` for B). Fields are read in the control cycle, against the control register value before its advance.
- R6: `valid_o` is high for one cycle, in the cycle after the last jump step. Consecutive strobes are therefore delta+1 cycles apart, and the strobe is never high two cycles running.
- R7: While `valid_o` is high, `key_o` equals the XOR of the three output bits when MODE=1. When MODE=2, it equals the XOR of the A and B output bits.
- R8: A load pulse writes all three seeds, returns the sequencer to the control state and clears `valid_o`, all at the next edge. An all-zero seed is stored as 1.
- R9: Outside a load, exactly one of the three registers advances in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Seed load pulse |
| seed1_i | input | L1 | Control register seed |
| seed2_i | input | L2 | Register A seed |
| seed3_i | input | L3 | Register B seed |
| idx_a_i | input | W*IW | Bit index fields for the A jump count |
| idx_b_i | input | W*IW | Bit index fields for the B jump count |
| key_o | output | 1 | Keystream bit, meaningful while valid_o is high |
| valid_o | output | 1 | One-cycle strobe per keystream bit |

## Verification
A wrong counter load or a wrong decoder output changes the round length, so the strobe shifts by at least one cycle in the round where the fault hits. A wrong tap, hold or branch corrupts the state of a generating register. That shows up as a keystream mismatch within a few strobes, because every strobe exposes bit 0 of both generating registers. A control-register fault surfaces through the branch choice and the jump lengths, and in MODE=1 through the output bit itself. Comparing both strobe timing and bit values on every round therefore pins most faults to the round in which they arise.

// File: rtl/ccjs_pkg.sv
package ccjs_pkg;
    typedef enum logic [2:0] {
        ST_CTRL  = 3'b100,
        ST_GEN_A = 3'b010,
        ST_GEN_B = 3'b001
    } ctl_state_e;
endpackage

// File: rtl/ccjs_lfsr.sv
module ccjs_lfsr #(
    parameter int             LEN  = 7,
    parameter logic [LEN-1:0] TAPS = 'h3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [LEN-1:0] seed_i,
    output logic [LEN-1:0] state_o,
    output logic           bit_o
);
    logic [LEN-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = (seed_i == '0) ? LEN'(1) : seed_i;
        end else if (step_i) begin
            state_d = {^(state_q & TAPS), state_q[LEN-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= LEN'(1);
        else         state_q <= state_d;
    end

    assign state_o = state_q;
    assign bit_o   = state_q[0];
endmodule

// File: rtl/ccjs_step_calc.sv
module ccjs_step_calc #(
    parameter int L1 = 64,
    parameter int W  = 2,
    parameter int IW = $clog2(L1)
) (
    input  logic [L1-1:0]   r1_i,
    input  logic [W*IW-1:0] idx_i,
    output logic [W:0]      delta_o
);
    logic [W-1:0] picked;

    for (genvar k = 0; k < W; k++) begin : g_pick
        logic [L1-1:0] hot;
        assign hot       = {{(L1-1){1'b0}}, 1'b1} << idx_i[k*IW +: IW];
        assign picked[k] = |(hot & r1_i);
    end

    assign delta_o = {1'b0, picked} + (W+1)'(1);
endmodule

// File: rtl/ccjs_ctrl.sv
module ccjs_ctrl
    import ccjs_pkg::*;
#(
    parameter int W = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       sel_i,
    input  logic [W:0] delta_a_i,
    input  logic [W:0] delta_b_i,
    output ctl_state_e state_o,
    output logic [2:0] en_o,
    output logic       done_o
);
    typedef struct packed {
        ctl_state_e st;
        logic [W:0] cnt;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        en_o   = 3'b000;
        done_o = 1'b0;
        if (load_i) begin
            ctl_d.st  = ST_CTRL;
            ctl_d.cnt = '0;
        end else begin
            case (ctl_q.st)
                ST_CTRL: begin
                    en_o = 3'b100;
                    if (sel_i) begin
                        ctl_d.st  = ST_GEN_A;
                        ctl_d.cnt = delta_a_i - (W+1)'(1);
                    end else begin
                        ctl_d.st  = ST_GEN_B;
                        ctl_d.cnt = delta_b_i - (W+1)'(1);
                    end
                end
                ST_GEN_A, ST_GEN_B: begin
                    en_o = (ctl_q.st == ST_GEN_A) ? 3'b010 : 3'b001;
                    if (ctl_q.cnt == '0) begin
                        ctl_d.st = ST_CTRL;
                        done_o   = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - (W+1)'(1);
                    end
                end
                default: begin
                    ctl_d.st  = ST_CTRL;
                    ctl_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q.st  <= ST_CTRL;
            ctl_q.cnt <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o = ctl_q.st;
endmodule

// File: rtl/ccjs_keygen.sv
module ccjs_keygen
    import ccjs_pkg::*;
#(
    parameter int            L1    = 64,
    parameter int            L2    = 7,
    parameter int            L3    = 5,
    parameter int            W     = 2,
    parameter int            MODE  = 1,
    parameter logic [L1-1:0] TAP1  = 'h1B,
    parameter logic [L2-1:0] TAP2  = 'h03,
    parameter logic [L3-1:0] TAP3  = 'h05,
    localparam int           IW    = $clog2(L1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic [L1-1:0]   seed1_i,
    input  logic [L2-1:0]   seed2_i,
    input  logic [L3-1:0]   seed3_i,
    input  logic [W*IW-1:0] idx_a_i,
    input  logic [W*IW-1:0] idx_b_i,
    output logic            key_o,
    output logic            valid_o
);
    typedef struct packed {
        logic valid;
    } top_s;

    top_s          top_d, top_q;
    ctl_state_e    ctl_state;
    logic [2:0]    step_en;
    logic          round_done;
    logic [W:0]    delta_a, delta_b;
    logic [L1-1:0] r1_state;
    logic [L2-1:0] r2_state;
    logic [L3-1:0] r3_state;
    logic          b1, b2, b3;

    ccjs_step_calc #(.L1(L1), .W(W), .IW(IW)) u_calc_a (
        .r1_i(r1_state), .idx_i(idx_a_i), .delta_o(delta_a)
    );
    ccjs_step_calc #(.L1(L1), .W(W), .IW(IW)) u_calc_b (
        .r1_i(r1_state), .idx_i(idx_b_i), .delta_o(delta_b)
    );

    ccjs_ctrl #(.W(W)) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
        .sel_i(r1_state[0]), .delta_a_i(delta_a), .delta_b_i(delta_b),
        .state_o(ctl_state), .en_o(step_en), .done_o(round_done)
    );

    ccjs_lfsr #(.LEN(L1), .TAPS(TAP1)) u_r1 (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_en[2]),
        .seed_i(seed1_i), .state_o(r1_state), .bit_o(b1)
    );
    ccjs_lfsr #(.LEN(L2), .TAPS(TAP2)) u_r2 (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_en[1]),
        .seed_i(seed2_i), .state_o(r2_state), .bit_o(b2)
    );
    ccjs_lfsr #(.LEN(L3), .TAPS(TAP3)) u_r3 (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_en[0]),
        .seed_i(seed3_i), .state_o(r3_state), .bit_o(b3)
    );

    always_comb begin
        top_d       = top_q;
        top_d.valid = round_done && !load_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) top_q.valid <= 1'b0;
        else         top_q       <= top_d;
    end

    if (MODE == 1) begin : g_mode_all
        assign key_o = b1 ^ b2 ^ b3;
    end else begin : g_mode_gen
        assign key_o = b2 ^ b3;
    end

    assign valid_o = top_q.valid;
endmodule

// File: rtl/ccjs_keygen_chk.sv
module ccjs_keygen_chk
    import ccjs_pkg::*;
#(
    parameter int L1 = 64,
    parameter int L2 = 7,
    parameter int L3 = 5
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          load_i,
    input ctl_state_e    ctl_state,
    input logic [2:0]    step_en,
    input logic          valid_o,
    input logic [L1-1:0] r1_state,
    input logic [L2-1:0] r2_state,
    input logic [L3-1:0] r3_state
);
    p_state_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(ctl_state) == 1);

    p_one_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |-> $countones(step_en) == 1);

    p_hold_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_state == ST_GEN_B && !load_i) |=> $stable(r2_state));

    p_hold_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_state == ST_GEN_A && !load_i) |=> $stable(r3_state));

    p_ctrl_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_state == ST_CTRL && !load_i) |=> r1_state != $past(r1_state));

    p_valid_in_ctrl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ctl_state == ST_CTRL);

    p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    p_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r1_state != '0 && r2_state != '0 && r3_state != '0);
endmodule

bind ccjs_keygen ccjs_keygen_chk #(.L1(L1), .L2(L2), .L3(L3)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .ctl_state(ctl_state),
    .step_en(step_en), .valid_o(valid_o), .r1_state(r1_state),
    .r2_state(r2_state), .r3_state(r3_state)
);

// File: tb/tb_ccjs_keygen.sv
`timescale 1ns/1ps
module tb_ccjs_keygen;
    localparam int L1 = 64;
    localparam int L2 = 7;
    localparam int L3 = 5;
    localparam logic [L1-1:0] T1 = 64'h1B;
    localparam logic [L2-1:0] T2 = 7'h03;
    localparam logic [L3-1:0] T3 = 5'h05;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [L1-1:0] seed1 = '0;
    logic [L2-1:0] seed2 = '0;
    logic [L3-1:0] seed3 = '0;
    logic [11:0]   ia = 12'h0C5;
    logic [11:0]   ib = 12'h3A7;
    logic          key1, val1, key2, val2;

    int vectors = 0;
    int fails = 0;

    logic [L1-1:0] m1;
    logic [L2-1:0] m2;
    logic [L3-1:0] m3;

    always #4 clk = ~clk;

    ccjs_keygen #(.MODE(1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed1_i(seed1),
        .seed2_i(seed2), .seed3_i(seed3), .idx_a_i(ia), .idx_b_i(ib),
        .key_o(key1), .valid_o(val1)
    );
    ccjs_keygen #(.MODE(2)) dut_m2 (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed1_i(seed1),
        .seed2_i(seed2), .seed3_i(seed3), .idx_a_i(ia), .idx_b_i(ib),
        .key_o(key2), .valid_o(val2)
    );

    function automatic logic [L1-1:0] st1(logic [L1-1:0] x);
        return {^(x & T1), x[L1-1:1]};
    endfunction
    function automatic logic [L2-1:0] st2(logic [L2-1:0] x);
        return {^(x & T2), x[L2-1:1]};
    endfunction
    function automatic logic [L3-1:0] st3(logic [L3-1:0] x);
        return {^(x & T3), x[L3-1:1]};
    endfunction
    function automatic int jump(logic [L1-1:0] r, logic [11:0] idx);
        return 1 + int'(r[idx[5:0]]) + 2 * int'(r[idx[11:6]]);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R2, R3, R4, R5 via model; R6 timing; R7 both modes
    task automatic run_bits(int n);
        for (int i = 0; i < n; i++) begin
            logic sel;
            int d;
            sel = m1[0];
            d = jump(m1, sel ? ia : ib);
            m1 = st1(m1);
            for (int j = 0; j < d; j++) begin
                if (sel) m2 = st2(m2);
                else     m3 = st3(m3);
            end
            for (int j = 0; j < d; j++) begin
                @(negedge clk);
                chk(!val1 && !val2, "R6 strobe low during jump (R4/R5 length)",
                    {62'd0, val1, val2}, 64'd0);
            end
            @(negedge clk);
            chk(val1 && val2, "R6 strobe after delta steps (R4/R5)",
                {62'd0, val1, val2}, 64'd3);
            chk(key1 == (m1[0] ^ m2[0] ^ m3[0]), "R7 mode 1 bit (R2/R3/R4)",
                64'(key1), 64'(m1[0] ^ m2[0] ^ m3[0]));
            chk(key2 == (m2[0] ^ m3[0]), "R7 mode 2 bit",
                64'(key2), 64'(m2[0] ^ m3[0]));
        end
    endtask

    // R8: load, zero seed replaced by 1
    task automatic do_load(logic [L1-1:0] s1, logic [L2-1:0] s2, logic [L3-1:0] s3,
                           logic [11:0] a, logic [11:0] b);
        seed1 = s1; seed2 = s2; seed3 = s3; ia = a; ib = b;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m1 = (s1 == '0) ? L1'(1) : s1;
        m2 = (s2 == '0) ? L2'(1) : s2;
        m3 = (s3 == '0) ? L3'(1) : s3;
        chk(!val1 && !val2, "R8 strobe cleared by load", {62'd0, val1, val2}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!val1, "R1 strobe low in reset", 64'(val1), 64'd0);
        chk(key1 == 1'b1, "R1 registers hold 1 (mode 1)", 64'(key1), 64'd1);
        chk(key2 == 1'b0, "R1 registers hold 1 (mode 2)", 64'(key2), 64'd0);
        rst_n = 1'b1;
        m1 = L1'(1); m2 = L2'(1); m3 = L3'(1);
        run_bits(60);

        @(negedge clk);
        do_load(64'hA5C3_1E0F_9B72_4D68, 7'h55, 5'h13, 12'h7FF, 12'h041);
        run_bits(30);

        do_load('0, '0, '0, 12'h0C2, 12'h105);
        run_bits(20);

        for (int p = 1; p < 64; p++) begin
            do_load(64'(p) * 64'h9E37_79B9_7F4A_7C15, 7'(p * 3), 5'(p),
                    {6'(64 - p), 6'(p)}, {6'((p * 5) % 63 + 1), 6'((p * 11) % 63 + 1)});
            run_bits(12);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(120000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule